// File: doc/BRIEF.md
# Multiplexed 8-bit handshake bus master

The block is a master for an external 8-bit bus on which address and data share the same pins. An internal client presents a byte, half-word or word read or write with a valid/ready handshake. The block turns the request into one, two or four consecutive byte cycles, lowest byte first. Each cycle starts on a pulse of a slower bus-clock enable. It first drives an address phase with an address latch strobe, then a data phase, and it ends on an external acknowledge. A fixed two-cycle completion delay follows the acknowledge, then chip select is released.

Read bytes are gathered into a 32-bit result by byte lane. A one-cycle done pulse marks the end of the whole access. The whole block runs on the fast internal clock. A parameter sets how many data-phase cycles must pass before the acknowledge is looked at.

Top module: `mux8_bus_master`

## Requirements
- R1: `req_ready` is high only when the block is idle. A request is taken on a clock edge with `req_valid` and `req_ready` both high. A request held on the inputs while an access is in progress is ignored and starts no extra bus cycle.
- R2: Size code 00 gives one byte cycle, 01 gives two and 10 gives four. The byte address of the cycles rises by one each time from the start address, which is taken as aligned to the size.
- R3: The address phase lasts one clock. In it `bus_cs_n` is low, `bus_ale` is high, `bus_ad_oe` is high, `bus_ad_out` carries byte address bits [15:0] and `bus_addr_hi` carries bits [23:16].
- R4: In the data phase `bus_ale` is low and `bus_addr_hi` is zero. On a write, `bus_ad_oe` is high, `bus_ad_out[7:0]` is the write byte, `bus_ad_out[15:8]` is zero and `bus_we_n` is low. On a read, `bus_ad_oe` is low and `bus_we_n` is high.
- R5: The byte written at byte address `a` is `req_wdata[8*a[1:0]+7 : 8*a[1:0]]`.
- R6: On a read, `bus_ad_in` is sampled on the clock edge at which the acknowledge is first taken. It is stored in `rdata[8*a[1:0]+7 : 8*a[1:0]]`. Lanes not read are zero, because the result is cleared when the request is taken. `rdata` is valid while `done` is high.
- R7: `bus_cs_n` falls only on a clock edge at which `bus_en` is high.
- R8: `bus_ack` is ignored during the first `ACK_WAIT` clocks of the data phase.
- R9: After the clock edge at which the acknowledge is taken, `bus_cs_n` stays low for exactly two more clocks and then goes high.
- R10: Whenever `bus_cs_n` is high, `bus_ad_oe` is low.
- R11: `done` is high for exactly one clock, with `bus_cs_n` high, after the final byte cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | One-clock pulse marking a slow bus-clock edge |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 half-word, 10 word |
| req_addr | input | 24 | Start byte address |
| req_wdata | input | 32 | Write data, byte lane by address |
| done | output | 1 | Access complete pulse |
| rdata | output | 32 | Assembled read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ale | output | 1 | Address latch strobe |
| bus_ad_out | output | 16 | Multiplexed address/data output value |
| bus_ad_oe | output | 1 | Output enable for the multiplexed pins |
| bus_ad_in | input | 8 | Read data on the low multiplexed lines |
| bus_addr_hi | output | 8 | Upper address lines [23:16] |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_ack | input | 1 | Data acknowledge from the device |

## Verification
Two events can meet in one clock. A stray acknowledge may arrive while the data-wait window is still counting, and a new request may be held on the inputs while the final byte's done pulse is raised. The bench drives a one-clock acknowledge pulse early in the data phase of a word write and holds a different request valid through that whole access. It then judges that chip select stays low through the window, that the bytes on the bus are those of the first request, and that no bus cycle follows the done pulse.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
    localparam int MBM_ADDR_W  = 24;
    localparam int MBM_AD_W    = 16;
    localparam int MBM_HI_W    = MBM_ADDR_W - MBM_AD_W;
    localparam int MBM_DATA_W  = 32;
    localparam int MBM_LANE_W  = 8;
    localparam int MBM_LANES   = MBM_DATA_W / MBM_LANE_W;
    localparam int MBM_IDX_W   = $clog2(MBM_LANES);
    localparam int MBM_BEAT_W  = MBM_IDX_W + 1;
    localparam int MBM_FIN_CYC = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_ADDR,
        ST_DWAIT,
        ST_ACKW,
        ST_FIN,
        ST_RECOV
    } state_e;

    typedef struct packed {
        logic                  write;
        size_e                 size;
        logic [MBM_ADDR_W-1:0] addr;
        logic [MBM_DATA_W-1:0] wdata;
    } req_t;

    function automatic logic [MBM_BEAT_W-1:0] beats_of(size_e s);
        case (s)
            SZ_HALF: beats_of = MBM_BEAT_W'(2);
            SZ_WORD: beats_of = MBM_BEAT_W'(4);
            default: beats_of = MBM_BEAT_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/mbm_seq.sv
module mbm_seq
    import mbm_pkg::*;
#(
    parameter int ACK_WAIT = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   bus_en,
    input  logic   start,
    input  logic   last,
    input  logic   bus_ack,
    output state_e state,
    output logic   ack_take,
    output logic   beat_adv,
    output logic   done,
    output logic   idle
);
    localparam int CMAX = (ACK_WAIT > MBM_FIN_CYC) ? ACK_WAIT : MBM_FIN_CYC;
    localparam int CW   = $clog2(CMAX + 1);

    state_e        nxt;
    logic [CW-1:0] cnt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (start) nxt = ST_SYNC;
            ST_SYNC:  if (bus_en) nxt = ST_ADDR;
            ST_ADDR:  nxt = ST_DWAIT;
            ST_DWAIT: if (cnt == CW'(ACK_WAIT - 1)) nxt = ST_ACKW;
            ST_ACKW:  if (bus_ack) nxt = ST_FIN;
            ST_FIN:   if (cnt == CW'(MBM_FIN_CYC - 1)) nxt = ST_RECOV;
            ST_RECOV: nxt = last ? ST_IDLE : ST_SYNC;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
        end
    end

    assign ack_take = (state == ST_ACKW) && bus_ack;
    assign beat_adv = (state == ST_RECOV) && !last;
    assign done     = (state == ST_RECOV) && last;
    assign idle     = (state == ST_IDLE);

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> !idle); // R1
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
endmodule

// File: rtl/mbm_lane.sv
module mbm_lane
    import mbm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  req_t                  req_in,
    input  logic                  beat_adv,
    output logic [MBM_ADDR_W-1:0] cur_addr,
    output logic [MBM_LANE_W-1:0] wbyte,
    output logic                  last,
    output logic                  is_write
);
    req_t                 held;
    logic [MBM_IDX_W-1:0] idx;
    logic [MBM_IDX_W-1:0] lane;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            idx  <= '0;
        end else if (start) begin
            held <= req_in;
            idx  <= '0;
        end else if (beat_adv) begin
            idx  <= idx + 1'b1;
        end
    end

    assign cur_addr = held.addr + MBM_ADDR_W'(idx);
    assign lane     = cur_addr[MBM_IDX_W-1:0];
    assign wbyte    = held.wdata[lane*MBM_LANE_W +: MBM_LANE_W];
    assign last     = ({1'b0, idx} == beats_of(held.size) - 1'b1);
    assign is_write = held.write;

    AST_ADDR_STEPS_UP: assert property (@(posedge clk) disable iff (rst)
        beat_adv |=> cur_addr[MBM_IDX_W-1:0] ==
                     MBM_IDX_W'($past(cur_addr[MBM_IDX_W-1:0]) + 1'b1)); // R2
endmodule

// File: rtl/mbm_rd_asm.sv
module mbm_rd_asm
    import mbm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  capture,
    input  logic [MBM_IDX_W-1:0]  lane,
    input  logic [MBM_LANE_W-1:0] din,
    output logic [MBM_DATA_W-1:0] rdata
);
    for (genvar g = 0; g < MBM_LANES; g++) begin : g_lane
        logic [MBM_LANE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst || start)
                q <= '0;
            else if (capture && lane == MBM_IDX_W'(g))
                q <= din;
        end
        assign rdata[g*MBM_LANE_W +: MBM_LANE_W] = q;
    end
endmodule

// File: rtl/mux8_bus_master.sv
module mux8_bus_master
    import mbm_pkg::*;
#(
    parameter int ACK_WAIT = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_en,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic [MBM_ADDR_W-1:0] req_addr,
    input  logic [MBM_DATA_W-1:0] req_wdata,
    output logic                  done,
    output logic [MBM_DATA_W-1:0] rdata,
    output logic                  bus_cs_n,
    output logic                  bus_ale,
    output logic [MBM_AD_W-1:0]   bus_ad_out,
    output logic                  bus_ad_oe,
    input  logic [MBM_LANE_W-1:0] bus_ad_in,
    output logic [MBM_HI_W-1:0]   bus_addr_hi,
    output logic                  bus_we_n,
    input  logic                  bus_ack
);
    state_e                state;
    logic                  idle, start, last, ack_take, beat_adv;
    logic                  is_write, data_ph;
    logic [MBM_ADDR_W-1:0] cur_addr;
    logic [MBM_LANE_W-1:0] wbyte;
    req_t                  req_in;

    assign start  = req_valid && idle;
    assign req_in = '{write: req_write, size: size_e'(req_size),
                      addr: req_addr, wdata: req_wdata};

    mbm_seq #(.ACK_WAIT(ACK_WAIT)) u_seq (
        .clk(clk), .rst(rst), .bus_en(bus_en), .start(start), .last(last),
        .bus_ack(bus_ack), .state(state), .ack_take(ack_take),
        .beat_adv(beat_adv), .done(done), .idle(idle)
    );

    mbm_lane u_lane (
        .clk(clk), .rst(rst), .start(start), .req_in(req_in),
        .beat_adv(beat_adv), .cur_addr(cur_addr), .wbyte(wbyte),
        .last(last), .is_write(is_write)
    );

    mbm_rd_asm u_rd (
        .clk(clk), .rst(rst), .start(start), .capture(ack_take && !is_write),
        .lane(cur_addr[MBM_IDX_W-1:0]), .din(bus_ad_in), .rdata(rdata)
    );

    assign data_ph     = (state == ST_DWAIT) || (state == ST_ACKW) || (state == ST_FIN);
    assign req_ready   = idle;
    assign bus_ale     = (state == ST_ADDR);
    assign bus_cs_n    = !(bus_ale || data_ph);
    assign bus_ad_oe   = bus_ale || (data_ph && is_write);
    assign bus_we_n    = !(data_ph && is_write);
    assign bus_addr_hi = bus_ale ? cur_addr[MBM_ADDR_W-1:MBM_AD_W] : '0;

    always_comb begin
        if (bus_ale)
            bus_ad_out = cur_addr[MBM_AD_W-1:0];
        else if (bus_ad_oe)
            bus_ad_out = {{(MBM_AD_W-MBM_LANE_W){1'b0}}, wbyte};
        else
            bus_ad_out = '0;
    end

    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (rst)
        bus_cs_n |-> !bus_ad_oe); // R10
    AST_START_ON_EN: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_cs_n) |-> $past(bus_en)); // R7
    AST_HI_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        (!bus_cs_n && !bus_ale) |-> bus_addr_hi == '0); // R4
    AST_WE_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        !bus_we_n |-> (!bus_cs_n && !bus_ale && bus_ad_oe)); // R4
    AST_DONE_DESEL: assert property (@(posedge clk) disable iff (rst)
        done |-> bus_cs_n); // R11
    AST_FIN_TWO: assert property (@(posedge clk) disable iff (rst)
        ack_take |=> !bus_cs_n ##1 !bus_cs_n ##1 bus_cs_n); // R9
endmodule

// File: tb/mux8_bus_master_bench.sv
module mux8_bus_master_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        done;
    logic [31:0] rdata;
    logic        bus_cs_n, bus_ale, bus_ad_oe, bus_we_n;
    logic [15:0] bus_ad_out;
    logic [7:0]  bus_ad_in = 8'h00;
    logic [7:0]  bus_addr_hi;
    logic        bus_ack = 1'b0;
    logic [1:0]  en_cnt;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) en_cnt <= 2'd0;
        else     en_cnt <= en_cnt + 2'd1;
    end
    assign bus_en = (en_cnt == 2'd3);

    mux8_bus_master #(.ACK_WAIT(2)) u_mux8_bus_master (
        .clk(clk), .rst(rst), .bus_en(bus_en), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_addr_hi(bus_addr_hi),
        .bus_we_n(bus_we_n), .bus_ack(bus_ack)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input logic [1:0] sz, input logic [23:0] a,
                         input logic [31:0] wd, input bit hold_junk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready when idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_addr = a; req_wdata = wd;
        @(negedge clk);
        chk(req_ready == 1'b0, "R1 ready low after accept", 32'(req_ready), 32'd0);
        if (hold_junk) begin
            req_write = ~wr; req_size = 2'b00;
            req_addr = 24'h55AA00; req_wdata = 32'hFFFF_FFFF;
        end else begin
            req_valid = 1'b0;
        end
    endtask

    task automatic beat(input bit wr, input logic [23:0] a, input logic [7:0] b,
                        input int extra, input bit early, input bit last,
                        input logic [31:0] exp_rd);
        do @(negedge clk); while (bus_cs_n);
        chk(en_cnt == 2'd0, "R7 start on bus enable", 32'(en_cnt), 32'd0);
        chk(bus_ale && bus_ad_oe, "R3 ale and oe in address phase",
            {30'd0, bus_ale, bus_ad_oe}, 32'd3);
        chk(bus_ad_out == a[15:0], "R3 low address", 32'(bus_ad_out), 32'(a[15:0]));
        chk(bus_addr_hi == a[23:16], "R3 high address", 32'(bus_addr_hi), 32'(a[23:16]));
        @(negedge clk);
        chk(!bus_ale && bus_addr_hi == 8'h00, "R4 data phase ale low, upper zero",
            {23'd0, bus_ale, bus_addr_hi}, 32'd0);
        chk(req_ready == 1'b0, "R1 busy", 32'(req_ready), 32'd0);
        if (wr) begin
            chk(bus_ad_oe && !bus_we_n, "R4 write drives and strobes",
                {30'd0, bus_ad_oe, bus_we_n}, 32'd2);
            chk(bus_ad_out == {8'h00, b}, "R5 write byte on low lines",
                32'(bus_ad_out), 32'(b));
        end else begin
            chk(!bus_ad_oe && bus_we_n, "R4 read releases pins",
                {30'd0, bus_ad_oe, bus_we_n}, 32'd1);
        end
        if (early) bus_ack = 1'b1;
        for (int i = 0; i < extra; i++) begin
            @(negedge clk);
            bus_ack = 1'b0;
            chk(bus_cs_n == 1'b0, "R8 cycle open before ack", 32'(bus_cs_n), 32'd0);
        end
        bus_ack = 1'b1;
        bus_ad_in = b;
        @(negedge clk);
        bus_ack = 1'b0;
        bus_ad_in = 8'h5A;
        chk(bus_cs_n == 1'b0, "R9 first completion clock", 32'(bus_cs_n), 32'd0);
        @(negedge clk);
        chk(bus_cs_n == 1'b0, "R9 second completion clock", 32'(bus_cs_n), 32'd0);
        @(negedge clk);
        chk(bus_cs_n == 1'b1, "R9 cs released", 32'(bus_cs_n), 32'd1);
        chk(bus_ad_oe == 1'b0, "R10 hi-z when deselected", 32'(bus_ad_oe), 32'd0);
        chk(done == last, "R11 done only after last byte", 32'(done), 32'(last));
        if (last && !wr)
            chk(rdata == exp_rd, "R6 assembled read data", rdata, exp_rd);
    endtask

    task automatic after_done();
        @(negedge clk);
        chk(done == 1'b0, "R11 done single pulse", 32'(done), 32'd0);
        chk(req_ready == 1'b1, "R1 idle after access", 32'(req_ready), 32'd1);
    endtask

    task automatic t_reset();
        chk(bus_cs_n && !bus_ad_oe && bus_we_n && !bus_ale,
            "R10 reset bus idle", {28'd0, bus_cs_n, bus_ad_oe, bus_we_n, bus_ale},
            32'hA);
        chk(req_ready && !done, "R1 reset ready, no done",
            {30'd0, req_ready, done}, 32'd2);
    endtask

    task automatic t_byte_read();
        issue(1'b0, 2'b00, 24'h123457, 32'h0, 1'b0);
        beat(1'b0, 24'h123457, 8'hC3, 2, 1'b0, 1'b1, 32'hC300_0000);
        after_done();
    endtask

    task automatic t_half_write();
        issue(1'b1, 2'b01, 24'hABCD02, 32'h1234_5678, 1'b0);
        beat(1'b1, 24'hABCD02, 8'h34, 2, 1'b0, 1'b0, 32'h0);
        beat(1'b1, 24'hABCD03, 8'h12, 3, 1'b0, 1'b1, 32'h0);
        after_done();
    endtask

    task automatic t_word_read();
        issue(1'b0, 2'b10, 24'h001000, 32'h0, 1'b0);
        beat(1'b0, 24'h001000, 8'h11, 2, 1'b0, 1'b0, 32'h0);
        beat(1'b0, 24'h001001, 8'h22, 5, 1'b0, 1'b0, 32'h0);
        beat(1'b0, 24'h001002, 8'h33, 3, 1'b0, 1'b0, 32'h0);
        beat(1'b0, 24'h001003, 8'h44, 7, 1'b0, 1'b1, 32'h4433_2211);
        after_done();
    endtask

    task automatic t_word_write_busy();
        issue(1'b1, 2'b10, 24'h7F00F4, 32'hDEAD_BEEF, 1'b1);
        beat(1'b1, 24'h7F00F4, 8'hEF, 4, 1'b1, 1'b0, 32'h0);
        beat(1'b1, 24'h7F00F5, 8'hBE, 2, 1'b0, 1'b0, 32'h0);
        beat(1'b1, 24'h7F00F6, 8'hAD, 2, 1'b1, 1'b0, 32'h0);
        beat(1'b1, 24'h7F00F7, 8'hDE, 2, 1'b0, 1'b1, 32'h0);
        chk(req_ready == 1'b0, "R1 held request not taken at done",
            32'(req_ready), 32'd0);
        req_valid = 1'b0;
        after_done();
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(bus_cs_n == 1'b1, "R1 ignored request starts no cycle",
                32'(bus_cs_n), 32'd1);
        end
    endtask

    task automatic t_byte_write();
        issue(1'b1, 2'b00, 24'h000001, 32'h0000_A500, 1'b0);
        beat(1'b1, 24'h000001, 8'hA5, 2, 1'b0, 1'b1, 32'h0);
        after_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_byte_read();
        t_half_write();
        t_word_read();
        t_word_write_busy();
        t_byte_write();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R11 watchdog expired act=%h exp=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule